// File: doc/BRIEF.md
# Tiled Fixed-Point Matrix Multiply-Accumulate Engine

This engine computes one output tile of the product C = alpha·A·B + beta·C when the full matrices are too large to keep on chip. The host splits the matrices into square tiles of TILE×TILE elements. For one output tile it sends the block a series of jobs, one per tile pair along the shared (K) dimension. Each job delivers an A tile and a B tile over a valid/ready input stream, and the block keeps both in local register memories that are read and written in a single cycle.

A multiply stage runs one multiply-accumulate per cycle over the buffered tiles. It scales each finished dot product by alpha and hands the element straight to a separate add stage, which folds it into a result tile held on chip. The add stage starts work when the first element is ready, not after the whole tile is done. The job marked as the last one along K also carries the prior C tile. When that job's pass completes, the block applies beta to the prior C tile, rounds and saturates each element to 16 bits, and streams the finished tile out. A done pulse follows the final output beat.

All operands are signed 16-bit fixed point with 8 fraction bits. Sums are held in 32-bit two's-complement registers that wrap on overflow.

Top module: `gemm_tile_engine`

## Requirements
- R1: After reset, busy, s_tready, m_tvalid and done are all 0. While busy is 0, s_tready and m_tvalid stay 0.
- R2: A start pulse seen while busy is 0 captures alpha, beta and last_k, and raises busy. The input stream then accepts beats in this order: the A tile in row-major order (element index row·TILE+col), then the B tile in row-major order, then, only when last_k was 1, the prior C tile in row-major order. s_tready is 1 only while beats are still owed.
- R3: For each element (i,j), the tile product is P = Σk A[i][k]·B[k][j], wrapped to 32 bits. The scaled value is S = (alpha·P) shifted right arithmetically by 8, wrapped to 32 bits.
- R4: Each job adds S into the on-chip result tile with 32-bit wrap. The result tile is zero after reset and after every emitted tile, so a run of jobs sums as one GEMM.
- R5: On a last_k job, each output element is F = R + beta·Cold (32-bit wrap). The value sent is (F + 128) shifted right arithmetically by 8, saturated to the range −32768..32767.
- R6: A last_k job emits exactly TILE·TILE beats in row-major order, with m_tlast set on the final beat only.
- R7: While m_tvalid is 1 and m_tready is 0, m_tdata and m_tlast hold, and no beat is lost or repeated.
- R8: done is 1 for exactly the one cycle after the final beat is accepted, and busy is 0 in that cycle.
- R9: A job with last_k = 0 emits no output beats, and busy returns to 0 after its pass.
- R10: A start pulse or a change of alpha, beta or last_k while busy is 1 has no effect on the job in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Job start pulse, accepted only while idle |
| alpha | input | 16 | Product scale factor, signed, 8 fraction bits |
| beta | input | 16 | Prior-C scale factor, signed, 8 fraction bits |
| last_k | input | 1 | Marks the final K job for this output tile |
| busy | output | 1 | A job is in progress |
| s_tdata | input | 16 | Input tile element |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Input beat accepted when high together with valid |
| m_tdata | output | 16 | Output tile element |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Downstream accepts the output beat |
| m_tlast | output | 1 | Final beat of the output tile |
| done | output | 1 | One-cycle pulse after the final output beat |

## Verification
The main function is exercised in several ways:

- A single job with alpha of 1.0 and beta of 0 isolates the multiply path.
- A chain of two non-last jobs followed by a last job with beta of 1.0 separates correct accumulation and clearing from a single-shot product, and shows that non-last jobs stay silent.
- Tiles of large positive and large negative values drive every element into saturation at each end.
- Random tiles with negative alpha and beta check sign handling in both the rounding and the wrap paths.
- A start pulse with a changed alpha, sent in the middle of a load, must leave the result untouched.
- Random gaps on the input and random back-pressure on the output show that beat order and values survive stalls.

// File: rtl/gemm_tile_pkg.sv
package gemm_tile_pkg;
  parameter int DATA_W = 16;
  parameter int ACC_W  = 32;
  parameter int FRAC   = 8;

  typedef logic signed [DATA_W-1:0] dat_t;
  typedef logic signed [ACC_W-1:0]  acc_t;
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_MAC, ST_OUT} state_t;

  // full-width signed product of two operands
  function automatic acc_t mul_raw(input dat_t a, input dat_t b);
    acc_t t;
    t = a * b;
    return t;
  endfunction

  // alpha times tile product, arithmetic shift back to the product scale
  function automatic acc_t scale_alpha(input dat_t a, input acc_t p);
    logic signed [DATA_W+ACC_W-1:0] wide;
    wide = a * p;
    return acc_t'(wide >>> FRAC);
  endfunction

  // fold beta times the prior element into the accumulated value
  function automatic acc_t merge_beta(input acc_t r, input dat_t b, input dat_t c);
    return r + mul_raw(b, c);
  endfunction

  // round half up, drop the fraction, clamp to the output range
  function automatic dat_t round_sat(input acc_t f);
    logic signed [ACC_W:0] t;
    logic signed [ACC_W:0] s;
    t = $signed({f[ACC_W-1], f}) + $signed((ACC_W+1)'(2 ** (FRAC - 1)));
    s = t >>> FRAC;
    if (&s[ACC_W:DATA_W-1] || ~|s[ACC_W:DATA_W-1])
      return dat_t'(s[DATA_W-1:0]);
    else if (s[ACC_W])
      return {1'b1, {(DATA_W-1){1'b0}}};
    else
      return {1'b0, {(DATA_W-1){1'b1}}};
  endfunction
endpackage

// File: rtl/gemm_tile_buf.sv
module gemm_tile_buf
  import gemm_tile_pkg::*;
#(
  parameter int TILE = 4
) (
  input  logic                          clk,
  input  logic                          wr_en,
  input  logic [1:0]                    wr_sel,
  input  logic [2*$clog2(TILE)-1:0]     wr_addr,
  input  dat_t                          wr_data,
  input  logic [2*$clog2(TILE)-1:0]     a_addr,
  input  logic [2*$clog2(TILE)-1:0]     b_addr,
  input  logic [2*$clog2(TILE)-1:0]     c_addr,
  output dat_t                          a_data,
  output dat_t                          b_data,
  output dat_t                          c_data
);
  localparam int IW    = 2 * $clog2(TILE);
  localparam int N     = TILE * TILE;
  localparam int BANKS = 3;

  logic [IW-1:0] rd_addr [BANKS];
  dat_t          rd_data [BANKS];

  assign rd_addr[0] = a_addr;
  assign rd_addr[1] = b_addr;
  assign rd_addr[2] = c_addr;

  // one register bank per operand tile: bank 0 = A, 1 = B, 2 = prior C
  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    dat_t mem [N];
    always_ff @(posedge clk) begin
      if (wr_en && wr_sel == 2'(g))
        mem[wr_addr] <= wr_data;
    end
    assign rd_data[g] = mem[rd_addr[g]];
  end

  assign a_data = rd_data[0];
  assign b_data = rd_data[1];
  assign c_data = rd_data[2];
endmodule

// File: rtl/gemm_mac_stage.sv
module gemm_mac_stage
  import gemm_tile_pkg::*;
#(
  parameter int TILE = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      go,
  input  dat_t                      alpha,
  output logic [2*$clog2(TILE)-1:0] a_addr,
  output logic [2*$clog2(TILE)-1:0] b_addr,
  input  dat_t                      a_data,
  input  dat_t                      b_data,
  output logic                      out_valid,
  output logic [2*$clog2(TILE)-1:0] out_idx,
  output acc_t                      out_val
);
  localparam int CW = $clog2(TILE);
  localparam int IW = 2 * CW;
  localparam logic [CW-1:0] KMAX = CW'(TILE - 1);

  logic          run;
  logic [CW-1:0] ci, cj, ck;

  // stage 1: operand product
  logic          v1, kf1, kl1;
  logic [IW-1:0] idx1;
  acc_t          prod1;
  // stage 2: running dot product
  logic          v2;
  logic [IW-1:0] idx2;
  acc_t          sum2;

  assign a_addr = {ci, ck};
  assign b_addr = {ck, cj};

  // issue loop: k innermost, one operand pair per cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      ci  <= '0;
      cj  <= '0;
      ck  <= '0;
    end else if (go) begin
      run <= 1'b1;
      ci  <= '0;
      cj  <= '0;
      ck  <= '0;
    end else if (run) begin
      ck <= ck + 1'b1;
      if (ck == KMAX) begin
        ck <= '0;
        cj <= cj + 1'b1;
        if (cj == KMAX) begin
          cj <= '0;
          ci <= ci + 1'b1;
          if (ci == KMAX) run <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1        <= 1'b0;
      kf1       <= 1'b0;
      kl1       <= 1'b0;
      idx1      <= '0;
      prod1     <= '0;
      v2        <= 1'b0;
      idx2      <= '0;
      sum2      <= '0;
      out_valid <= 1'b0;
      out_idx   <= '0;
      out_val   <= '0;
    end else begin
      v1    <= run;
      kf1   <= (ck == '0);
      kl1   <= (ck == KMAX);
      idx1  <= {ci, cj};
      prod1 <= mul_raw(a_data, b_data);

      v2 <= v1 && kl1;
      if (v1) begin
        sum2 <= kf1 ? prod1 : sum2 + prod1;
        idx2 <= idx1;
      end

      out_valid <= v2;
      out_idx   <= idx2;
      out_val   <= scale_alpha(alpha, sum2);
    end
  end
endmodule

// File: rtl/gemm_add_stage.sv
module gemm_add_stage
  import gemm_tile_pkg::*;
#(
  parameter int TILE = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      wr,
  input  logic [2*$clog2(TILE)-1:0] wr_idx,
  input  acc_t                      wr_val,
  input  logic [2*$clog2(TILE)-1:0] rd_idx,
  output acc_t                      rd_val
);
  localparam int IW = 2 * $clog2(TILE);
  localparam int N  = TILE * TILE;
  localparam logic [IW-1:0] LAST_IDX = IW'(N - 1);

  acc_t acc_mem [N];
  logic fresh;

  // fresh marks a result tile whose stored words are stale and read as zero
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      fresh <= 1'b1;
    else if (clr)
      fresh <= 1'b1;
    else if (wr && wr_idx == LAST_IDX)
      fresh <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (wr)
      acc_mem[wr_idx] <= (fresh ? '0 : acc_mem[wr_idx]) + wr_val;
  end

  assign rd_val = acc_mem[rd_idx];
endmodule

// File: rtl/gemm_tile_engine.sv
module gemm_tile_engine
  import gemm_tile_pkg::*;
#(
  parameter int TILE = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] alpha,
  input  logic [15:0] beta,
  input  logic        last_k,
  output logic        busy,
  input  logic [15:0] s_tdata,
  input  logic        s_tvalid,
  output logic        s_tready,
  output logic [15:0] m_tdata,
  output logic        m_tvalid,
  input  logic        m_tready,
  output logic        m_tlast,
  output logic        done
);
  localparam int IW = 2 * $clog2(TILE);
  localparam int N  = TILE * TILE;
  localparam int LW = IW + 2;
  localparam logic [IW-1:0] LAST_IDX = IW'(N - 1);
  localparam logic [LW-1:0] LD_TWO   = LW'(2 * N - 1);
  localparam logic [LW-1:0] LD_THREE = LW'(3 * N - 1);

  state_t        state;
  dat_t          alpha_q, beta_q;
  logic          last_q;
  logic [LW-1:0] ld_cnt;
  logic [IW-1:0] out_idx;
  logic          done_q;

  // named internal events, also observed by the checker
  logic          ld_fire, ld_final, mac_go;
  logic          add_wr;
  logic [IW-1:0] add_idx;
  acc_t          add_val;
  logic          out_fire, acc_clr;

  logic [IW-1:0] a_addr, b_addr;
  dat_t          a_data, b_data, c_data;
  acc_t          acc_rd;

  assign ld_fire  = (state == ST_LOAD) && s_tvalid;
  assign ld_final = ld_cnt == (last_q ? LD_THREE : LD_TWO);
  assign mac_go   = ld_fire && ld_final;
  assign out_fire = (state == ST_OUT) && m_tready;
  assign acc_clr  = out_fire && (out_idx == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      alpha_q <= '0;
      beta_q  <= '0;
      last_q  <= 1'b0;
      ld_cnt  <= '0;
      out_idx <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          alpha_q <= dat_t'(alpha);
          beta_q  <= dat_t'(beta);
          last_q  <= last_k;
          ld_cnt  <= '0;
          state   <= ST_LOAD;
        end
        ST_LOAD: if (ld_fire) begin
          ld_cnt <= ld_cnt + 1'b1;
          if (ld_final) state <= ST_MAC;
        end
        ST_MAC: if (add_wr && add_idx == LAST_IDX) begin
          out_idx <= '0;
          state   <= last_q ? ST_OUT : ST_IDLE;
        end
        ST_OUT: if (out_fire) begin
          out_idx <= out_idx + 1'b1;
          if (out_idx == LAST_IDX) begin
            state  <= ST_IDLE;
            done_q <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  gemm_tile_buf #(.TILE(TILE)) buf_i (
    .clk     (clk),
    .wr_en   (ld_fire),
    .wr_sel  (ld_cnt[LW-1:IW]),
    .wr_addr (ld_cnt[IW-1:0]),
    .wr_data (dat_t'(s_tdata)),
    .a_addr  (a_addr),
    .b_addr  (b_addr),
    .c_addr  (out_idx),
    .a_data  (a_data),
    .b_data  (b_data),
    .c_data  (c_data)
  );

  gemm_mac_stage #(.TILE(TILE)) mac_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (mac_go),
    .alpha     (alpha_q),
    .a_addr    (a_addr),
    .b_addr    (b_addr),
    .a_data    (a_data),
    .b_data    (b_data),
    .out_valid (add_wr),
    .out_idx   (add_idx),
    .out_val   (add_val)
  );

  gemm_add_stage #(.TILE(TILE)) add_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (acc_clr),
    .wr     (add_wr),
    .wr_idx (add_idx),
    .wr_val (add_val),
    .rd_idx (out_idx),
    .rd_val (acc_rd)
  );

  assign busy     = (state != ST_IDLE);
  assign s_tready = (state == ST_LOAD);
  assign m_tvalid = (state == ST_OUT);
  assign m_tlast  = (state == ST_OUT) && (out_idx == LAST_IDX);
  assign m_tdata  = round_sat(merge_beta(acc_rd, beta_q, c_data));
  assign done     = done_q;
endmodule

// File: rtl/gemm_tile_engine_chk.sv
module gemm_tile_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        s_tready,
  input logic [15:0] m_tdata,
  input logic        m_tvalid,
  input logic        m_tready,
  input logic        m_tlast,
  input logic        done,
  input logic        add_wr
);
  // R1: an idle block neither accepts nor offers data
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !s_tready && !m_tvalid);

  // R2: loading never overlaps the multiply pass or the output drain
  p_load_alone_r2: assert property (@(posedge clk) disable iff (!rst_n)
    s_tready |-> !m_tvalid && !add_wr);

  // R3: elements reach the add stage only inside a job, outside load and drain
  p_add_in_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    add_wr |-> busy && !s_tready && !m_tvalid);

  // R7: a stalled beat holds its value
  p_hold_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tlast));

  // R8: the final accepted beat is followed by done with the block idle
  p_done_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && m_tready && m_tlast |=> done && !busy);

  // R8: done has no other cause
  p_done_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(m_tvalid && m_tready && m_tlast));
endmodule

bind gemm_tile_engine gemm_tile_engine_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .s_tready (s_tready),
  .m_tdata  (m_tdata),
  .m_tvalid (m_tvalid),
  .m_tready (m_tready),
  .m_tlast  (m_tlast),
  .done     (done),
  .add_wr   (add_wr)
);

// File: tb/gemm_tile_engine_tb_top.sv
module gemm_tile_engine_tb_top;
  localparam int T = 4;
  localparam int N = T * T;

  logic        clk = 1'b0;
  logic        rst_n, start, last_k, busy;
  logic [15:0] alpha, beta;
  logic [15:0] s_tdata, m_tdata;
  logic        s_tvalid, s_tready, m_tvalid, m_tready, m_tlast, done;

  always #5 clk = ~clk;

  gemm_tile_engine #(.TILE(T)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .alpha(alpha), .beta(beta),
    .last_k(last_k), .busy(busy), .s_tdata(s_tdata), .s_tvalid(s_tvalid),
    .s_tready(s_tready), .m_tdata(m_tdata), .m_tvalid(m_tvalid),
    .m_tready(m_tready), .m_tlast(m_tlast), .done(done)
  );

  int  n_chk = 0;
  int  n_bad = 0;
  bit  cmp_on = 0;
  bit  stall_mode = 0;
  bit  done_exp = 0;
  int  exp_q[$];
  int  racc[N];
  int  ta[N], tb[N], tc[N];

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  // reference: one job worth of R3, R4 and R5 arithmetic, in plain integers
  task automatic model_job(int al, int be, bit lst);
    for (int e = 0; e < N; e++) begin
      longint p = 0;
      int     s, f;
      longint r;
      for (int k = 0; k < T; k++)
        p += longint'(ta[(e / T) * T + k]) * longint'(tb[k * T + (e % T)]);
      s = int'((longint'(al) * longint'(int'(p))) >>> 8);
      racc[e] = int'(longint'(racc[e]) + longint'(s));
      if (lst) begin
        f = int'(longint'(racc[e]) + longint'(be) * longint'(tc[e]));
        r = (longint'(f) + 128) >>> 8;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        exp_q.push_back(int'(r));
        racc[e] = 0;
      end
    end
  endtask

  // per-clock comparison of the output side against the reference queue
  always @(negedge clk) begin
    if (cmp_on) begin
      chk(done === done_exp, "R8 done pulse", longint'(done), longint'(done_exp));
      if (done_exp) chk(busy === 1'b0, "R8 busy low with done", longint'(busy), 0);
      done_exp = 0;
      if (m_tvalid) begin
        if (exp_q.size() == 0)
          chk(0, "R9 beat with nothing owed", longint'($signed(m_tdata)), 0);
        else begin
          chk($signed(m_tdata) == exp_q[0], "R3/R4/R5 element value",
              longint'($signed(m_tdata)), longint'(exp_q[0]));
          chk(m_tlast == (exp_q.size() == 1), "R6 tlast position",
              longint'(m_tlast), longint'(exp_q.size() == 1));
        end
      end
      m_tready = stall_mode ? ($urandom % 3 == 0) : 1'b1;
      if (m_tvalid && m_tready && exp_q.size() > 0) begin
        if (m_tlast) done_exp = 1;
        void'(exp_q.pop_front());
      end
    end
  end

  task automatic fill_rand(int lo, int hi);
    for (int e = 0; e < N; e++) begin
      ta[e] = $urandom_range(hi - lo, 0) + lo;
      tb[e] = $urandom_range(hi - lo, 0) + lo;
      tc[e] = $urandom_range(hi - lo, 0) + lo;
    end
  endtask

  task automatic job(int al, int be, bit lst, bit poke);
    int k = 0;
    int total = lst ? 3 * N : 2 * N;
    bit hs;
    while (busy) @(negedge clk);
    model_job(al, be, lst);
    start  = 1'b1;
    alpha  = 16'(al);
    beta   = 16'(be);
    last_k = lst;
    @(negedge clk);
    start = 1'b0;
    chk(s_tready === 1'b1 && busy === 1'b1, "R2 load opens after start",
        longint'(s_tready), 1);
    while (k < total) begin
      s_tvalid = ($urandom % 4 != 0);
      s_tdata  = (k < N) ? 16'(ta[k]) : (k < 2 * N) ? 16'(tb[k - N]) : 16'(tc[k - 2 * N]);
      // R10: a second start with different scalars during the load
      start  = poke && (k == 3);
      alpha  = poke ? 16'(0) : 16'(al);
      beta   = poke ? 16'(-al) : 16'(be);
      last_k = poke ? ~lst : lst;
      hs = s_tvalid && s_tready;
      @(negedge clk);
      if (hs) k++;
    end
    s_tvalid = 1'b0;
    start    = 1'b0;
    @(negedge clk);
    chk(s_tready === 1'b0, "R2 no extra beats accepted", longint'(s_tready), 0);
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; alpha = '0; beta = '0; last_k = 1'b0;
    s_tdata = '0; s_tvalid = 1'b0; m_tready = 1'b0;
    for (int e = 0; e < N; e++) racc[e] = 0;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R1 reset busy", longint'(busy), 0);
    chk(s_tready === 1'b0, "R1 reset s_tready", longint'(s_tready), 0);
    chk(m_tvalid === 1'b0, "R1 reset m_tvalid", longint'(m_tvalid), 0);
    chk(done === 1'b0, "R1 reset done", longint'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_on = 1;

    // single shot, alpha 1.0, beta 0
    fill_rand(-512, 511);
    job(256, 0, 1'b1, 1'b0);

    // R4 and R9: two silent K jobs then the closing one with beta 1.0
    stall_mode = 1;
    fill_rand(-512, 511);
    job(128, 0, 1'b0, 1'b0);
    while (busy) @(negedge clk);
    chk(exp_q.size() == 0, "R9 no beats after non-last job", exp_q.size(), 0);
    fill_rand(-512, 511);
    job(384, 0, 1'b0, 1'b0);
    fill_rand(-512, 511);
    job(256, 256, 1'b1, 1'b0);

    // R5: saturation at both ends
    for (int e = 0; e < N; e++) begin ta[e] = 16384; tb[e] = 16384; tc[e] = 0; end
    job(256, 0, 1'b1, 1'b0);
    for (int e = 0; e < N; e++) begin ta[e] = -16384; tb[e] = 16384; tc[e] = 0; end
    job(256, 0, 1'b1, 1'b0);

    // R10: start and scalar changes while busy are ignored
    fill_rand(-512, 511);
    job(200, 100, 1'b1, 1'b1);

    // R7: random back-pressure with signed scalars
    for (int n = 0; n < 6; n++) begin
      fill_rand(-2048, 2047);
      job(int'($urandom_range(1024, 0)) - 512, int'($urandom_range(1024, 0)) - 512,
          (n % 2 == 1), 1'b0);
    end

    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R6 every owed beat delivered", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule